// File: doc/BRIEF.md
# NAND Page Buffer and Array Datapath

This block is the data half of a small NAND flash device model. It holds its storage in an on-chip single-port RAM. Each page has a main data area and a spare area one thirty-second of that size. A command decoder outside the block sends one-cycle events with a page index, a column and an extra start offset. The block then streams bytes out on read strobes and collects bytes on write strobes. It merges collected bytes into the array with a bitwise AND on a program commit, and it fills a whole erase block with 0xFF on an erase. It also serves the identification and status bytes.

The array is single-ported, so clearing after reset, erasing and programming take many cycles. During those cycles `ready` is low. The controller has five states:
- ST_INIT clears the array after reset and moves to ST_IDLE after the last byte.
- ST_IDLE serves reads and takes events. A valid commit moves it to ST_PRG_RD, and a valid erase moves it to ST_ERASE.
- ST_ERASE writes 0xFF over the block and returns to ST_IDLE.
- ST_PRG_RD and ST_PRG_WR alternate for each buffered byte. The first fetches the stored byte and the second writes back the AND. After the last byte, or at the end of the row, the controller returns to ST_IDLE.

Top module: `nand_page_datapath`

## Requirements
- R1: After reset the controller clears the whole array to 0xFF; `ready` is low from the first cycle after reset until that clear completes, then high.
- R2: After a read event, the first read strobe starts at the given column; a read strobe returns the byte on `rd_data` in the following cycle; a stream delivers (page + spare − start) bytes, and further strobes return 0x00.
- R3: With `spare_dis` high at the first strobe, the stream length is (page − start) bytes.
- R4: The start position of a stream is column plus `off_in`; the offset applies to that one load only and is cleared once used.
- R5: A commit stores (stored byte AND buffered byte) for each buffered byte starting at the program column, so programming only clears bits.
- R6: With `wp_n` low, a commit or an erase leaves the array unchanged and `ready` stays high.
- R7: Program data bytes beyond page + spare bytes are discarded, and a commit never writes past the end of its page row.
- R8: An erase writes 0xFF over every byte of the 2^ERASE_SHIFT-page block that holds the given page; pages outside the block are untouched.
- R9: After a status event, every strobe returns {wp_n, ready, 6'b0}, with bit 7 = `wp_n` and bit 6 = ready, and moves no read position. A status event is taken even while busy.
- R10: After an identification event, strobes return the manufacturer code, the device code, 0xA5, then 0x15 (8-bit large page), 0x55 (16-bit large page) or 0xC0 (small page), and after that 0x00.
- R11: A read strobe with `ce_n` high returns 0x00 and consumes nothing from the stream.
- R12: A read, program or erase whose page index is PAGES or more is ignored: reads return 0x00 and no array byte changes.
- R13: `ready` goes low in the cycle after an accepted commit or erase and stays low until the operation ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip enable for strobes |
| wp_n | input | 1 | Active-low write protect |
| spare_dis | input | 1 | Excludes the spare area from read streams |
| ev_read | input | 1 | Read event: latch page, column and offset |
| ev_prog_start | input | 1 | Start program data entry at page and column |
| ev_prog_commit | input | 1 | Merge buffered bytes into the array |
| ev_erase | input | 1 | Erase the block holding `page_in` |
| ev_status | input | 1 | Switch output to the status byte |
| ev_read_id | input | 1 | Switch output to the identification bytes |
| page_in | input | PAGE_AW | Page index |
| col_in | input | COL_W | Column within the page row |
| off_in | input | COL_W | Extra start offset for the next load |
| wr_strobe | input | 1 | Program data byte strobe |
| wr_data | input | 8 | Program data byte |
| rd_strobe | input | 1 | Read strobe |
| rd_data | output | 8 | Byte returned for the previous strobe |
| ready | output | 1 | High when no clear, erase or program runs |

## Verification
The read path is tried with several stream starts: column zero, a mid-page column with and without `spare_dis`, and a start inside the spare area given through the offset input. Together these separate a wrong length formula from a wrong start position. Program data is chosen so that a second program over the first shows AND behaviour rather than overwrite. A write-protected program and an overlong program are checked against neighbouring pages, which shows whether bytes leak or wrap. Status reads are made both while an erase runs and after it, so a status byte that was frozen can be told apart from one that is live.

// File: rtl/nand_dp_pkg.sv
`timescale 1ns/1ps
package nand_dp_pkg;
    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_ERASE,
        ST_PRG_RD,
        ST_PRG_WR
    } dp_state_t;

    typedef enum logic [2:0] {
        MD_NONE,
        MD_ARRAY,
        MD_PROG,
        MD_STATUS,
        MD_ID
    } dp_mode_t;
endpackage

// File: rtl/nand_array_ram.sv
`timescale 1ns/1ps
module nand_array_ram #(
    parameter int DEPTH = 1056,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    q
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) cells[addr] <= wdata;
            else    q <= cells[addr];
        end
    end
endmodule

// File: rtl/nand_prog_buffer.sv
`timescale 1ns/1ps
module nand_prog_buffer #(
    parameter int ROW   = 66,
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [7:0]       din,
    input  logic [LEN_W-1:0] rd_idx,
    output logic [7:0]       rd_byte,
    output logic [LEN_W-1:0] len
);
    localparam logic [LEN_W-1:0] CAP = LEN_W'(ROW);

    logic [7:0] slot [ROW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  len <= '0;
        else if (clear)              len <= '0;
        else if (push && len < CAP)  len <= len + LEN_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!clear && push && len < CAP) slot[len] <= din;
    end

    assign rd_byte = slot[rd_idx];
endmodule

// File: rtl/nand_id_bytes.sv
`timescale 1ns/1ps
module nand_id_bytes #(
    parameter logic [7:0] MFR_CODE   = 8'hEC,
    parameter logic [7:0] DEV_CODE   = 8'hF1,
    parameter bit         LARGE_PAGE = 1'b1,
    parameter bit         WIDE_BUS   = 1'b0
) (
    input  logic [2:0] idx,
    output logic [7:0] id_byte
);
    logic [7:0] geo_byte;

    generate
        if (LARGE_PAGE && WIDE_BUS) begin : g_lp16
            assign geo_byte = 8'h55;
        end else if (LARGE_PAGE) begin : g_lp8
            assign geo_byte = 8'h15;
        end else begin : g_sp
            assign geo_byte = 8'hC0;
        end
    endgenerate

    always_comb begin
        unique case (idx)
            3'd0:    id_byte = MFR_CODE;
            3'd1:    id_byte = DEV_CODE;
            3'd2:    id_byte = 8'hA5;
            3'd3:    id_byte = geo_byte;
            default: id_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/nand_page_datapath.sv
`timescale 1ns/1ps
module nand_page_datapath
    import nand_dp_pkg::*;
#(
    parameter int         PAGE_BYTES  = 64,
    parameter int         PAGES       = 16,
    parameter int         ERASE_SHIFT = 2,
    parameter int         PAGE_AW     = 5,
    parameter int         COL_W       = $clog2(PAGE_BYTES + PAGE_BYTES / 32) + 2,
    parameter logic [7:0] MFR_CODE    = 8'hEC,
    parameter logic [7:0] DEV_CODE    = 8'hF1,
    parameter bit         LARGE_PAGE  = 1'b1,
    parameter bit         WIDE_BUS    = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce_n,
    input  logic               wp_n,
    input  logic               spare_dis,
    input  logic               ev_read,
    input  logic               ev_prog_start,
    input  logic               ev_prog_commit,
    input  logic               ev_erase,
    input  logic               ev_status,
    input  logic               ev_read_id,
    input  logic [PAGE_AW-1:0] page_in,
    input  logic [COL_W-1:0]   col_in,
    input  logic [COL_W-1:0]   off_in,
    input  logic               wr_strobe,
    input  logic [7:0]         wr_data,
    input  logic               rd_strobe,
    output logic [7:0]         rd_data,
    output logic               ready
);
    localparam int SPARE_BYTES = PAGE_BYTES / 32;
    localparam int ROW         = PAGE_BYTES + SPARE_BYTES;
    localparam int DEPTH       = PAGES * ROW;
    localparam int MEM_AW      = $clog2(DEPTH);
    localparam int LEN_W       = $clog2(ROW + 1);
    localparam int CNT_W       = $clog2(DEPTH + 1);
    localparam int BLK         = ROW << ERASE_SHIFT;

    localparam logic [COL_W-1:0]   ROW_C    = COL_W'(ROW);
    localparam logic [COL_W-1:0]   PAGE_C   = COL_W'(PAGE_BYTES);
    localparam logic [PAGE_AW-1:0] PAGES_C  = PAGE_AW'(PAGES);
    localparam logic [MEM_AW-1:0]  ROW_M    = MEM_AW'(ROW);
    localparam logic [CNT_W-1:0]   DEPTH_M1 = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0]   BLK_M1   = CNT_W'(BLK - 1);
    localparam logic [CNT_W-1:0]   ROW_N    = CNT_W'(ROW);

    dp_state_t          state_q, state_d;
    dp_mode_t           mode_q;
    logic [PAGE_AW-1:0] page_q;
    logic [COL_W-1:0]   col_q, off_q, pend_q;
    logic [CNT_W-1:0]   idx_q;
    logic [MEM_AW-1:0]  base_q;
    logic [2:0]         id_cnt_q;
    logic               src_ram_q;
    logic [7:0]         byte_q;

    logic               ram_en, ram_we;
    logic [MEM_AW-1:0]  ram_addr;
    logic [7:0]         ram_wdata, ram_q;
    logic [7:0]         buf_byte, id_byte;
    logic [LEN_W-1:0]   buf_len;

    logic               idle, rd_go, any_ev, pg_ok;
    logic               arr_rd, arr_hit, commit_ok, erase_ok, prg_last, buf_push;
    logic [COL_W-1:0]   start_c, total_c, arr_col;
    logic [MEM_AW-1:0]  row_base, erase_base, prg_addr;
    logic [PAGE_AW-1:0] blk_page;

    assign idle     = (state_q == ST_IDLE);
    assign ready    = idle;
    assign rd_go    = rd_strobe && !ce_n;
    assign any_ev   = ev_read | ev_prog_start | ev_prog_commit | ev_erase
                    | ev_status | ev_read_id;
    assign pg_ok    = page_q < PAGES_C;
    assign start_c  = col_q + off_q;
    assign total_c  = spare_dis ? PAGE_C : ROW_C;
    assign arr_rd   = idle && mode_q == MD_ARRAY && rd_go && !any_ev;
    assign arr_hit  = arr_rd && (pend_q != '0 || (pg_ok && start_c < total_c));
    assign arr_col  = (pend_q != '0) ? col_q : start_c;
    assign row_base = MEM_AW'(page_q) * ROW_M;
    assign blk_page = (page_in >> ERASE_SHIFT) << ERASE_SHIFT;
    assign erase_base = MEM_AW'(blk_page) * ROW_M;
    assign prg_addr = base_q + MEM_AW'(col_q) + MEM_AW'(idx_q);
    assign commit_ok = ev_prog_commit && mode_q == MD_PROG && wp_n && pg_ok
                    && buf_len != '0 && col_q < ROW_C;
    assign erase_ok = ev_erase && !ev_prog_commit && wp_n && page_in < PAGES_C;
    assign prg_last = (CNT_W'(buf_len) == idx_q + CNT_W'(1))
                   || (CNT_W'(col_q) + idx_q + CNT_W'(1) >= ROW_N);
    assign buf_push = idle && mode_q == MD_PROG && wr_strobe && !ce_n && !any_ev;

    nand_array_ram #(.DEPTH(DEPTH), .AW(MEM_AW)) u_ram (
        .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
        .wdata(ram_wdata), .q(ram_q)
    );

    nand_prog_buffer #(.ROW(ROW), .LEN_W(LEN_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .clear(idle && ev_prog_start), .push(buf_push), .din(wr_data),
        .rd_idx(LEN_W'(idx_q)), .rd_byte(buf_byte), .len(buf_len)
    );

    nand_id_bytes #(
        .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE),
        .LARGE_PAGE(LARGE_PAGE), .WIDE_BUS(WIDE_BUS)
    ) u_id (
        .idx(id_cnt_q), .id_byte(id_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = '0;
        ram_wdata = 8'hFF;
        unique case (state_q)
            ST_INIT: begin
                ram_en   = 1'b1;
                ram_we   = 1'b1;
                ram_addr = MEM_AW'(idx_q);
                if (idx_q == DEPTH_M1) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (commit_ok)     state_d = ST_PRG_RD;
                else if (erase_ok) state_d = ST_ERASE;
                else if (arr_hit) begin
                    ram_en   = 1'b1;
                    ram_addr = row_base + MEM_AW'(arr_col);
                end
            end
            ST_ERASE: begin
                ram_en   = 1'b1;
                ram_we   = 1'b1;
                ram_addr = base_q + MEM_AW'(idx_q);
                if (idx_q == BLK_M1) state_d = ST_IDLE;
            end
            ST_PRG_RD: begin
                ram_en   = 1'b1;
                ram_addr = prg_addr;
                state_d  = ST_PRG_WR;
            end
            ST_PRG_WR: begin
                ram_en    = 1'b1;
                ram_we    = 1'b1;
                ram_addr  = prg_addr;
                ram_wdata = ram_q & buf_byte;
                state_d   = prg_last ? ST_IDLE : ST_PRG_RD;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            base_q <= '0;
        end else begin
            if (state_d == ST_IDLE) idx_q <= '0;
            else if (ram_we)        idx_q <= idx_q + CNT_W'(1);
            if (idle && commit_ok)     base_q <= row_base;
            else if (idle && erase_ok) base_q <= erase_base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MD_NONE;
            page_q   <= '0;
            col_q    <= '0;
            off_q    <= '0;
            pend_q   <= '0;
            id_cnt_q <= '0;
        end else if (ev_status) begin
            mode_q <= MD_STATUS;
        end else if (idle) begin
            if (ev_read) begin
                mode_q <= MD_ARRAY;
                page_q <= page_in;
                col_q  <= col_in;
                off_q  <= off_in;
                pend_q <= '0;
            end else if (ev_prog_start) begin
                mode_q <= MD_PROG;
                page_q <= page_in;
                col_q  <= col_in;
            end else if (ev_read_id) begin
                mode_q   <= MD_ID;
                id_cnt_q <= '0;
            end else if (ev_erase || ev_prog_commit) begin
                mode_q <= MD_NONE;
            end else if (arr_rd) begin
                off_q <= '0;
                if (arr_hit) begin
                    col_q  <= arr_col + COL_W'(1);
                    pend_q <= (pend_q != '0) ? pend_q - COL_W'(1)
                                             : total_c - start_c - COL_W'(1);
                end
            end else if (mode_q == MD_ID && rd_go && id_cnt_q < 3'd4) begin
                id_cnt_q <= id_cnt_q + 3'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_ram_q <= 1'b0;
            byte_q    <= 8'h00;
        end else if (rd_strobe) begin
            src_ram_q <= arr_hit;
            if (ce_n)                                    byte_q <= 8'h00;
            else if (mode_q == MD_STATUS)                byte_q <= {wp_n, idle, 6'b0};
            else if (mode_q == MD_ID && idle && !any_ev) byte_q <= id_byte;
            else                                         byte_q <= 8'h00;
        end
    end

    assign rd_data = src_ram_q ? ram_q : byte_q;
endmodule

// File: rtl/nand_dp_checker.sv
`timescale 1ns/1ps
module nand_dp_checker #(
    parameter int PAGE_AW = 5,
    parameter int COL_W   = 9,
    parameter int MEM_AW  = 11,
    parameter int PAGES   = 16,
    parameter int DEPTH   = 1056
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ce_n,
    input logic               wp_n,
    input logic               rd_strobe,
    input logic [7:0]         rd_data,
    input logic               ready,
    input logic               ev_erase,
    input logic               ev_prog_commit,
    input logic               ev_ptr,
    input logic [PAGE_AW-1:0] page_in,
    input logic               ram_en,
    input logic               ram_we,
    input logic [MEM_AW-1:0]  ram_addr,
    input logic               status_mode,
    input logic [COL_W-1:0]   col_q
);
    // R11: strobe with chip disabled yields zero
    a_r11_ce_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && ce_n) |=> rd_data == 8'h00);

    // R9: status byte carries protect bit and zero low bits
    a_r9_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (status_mode && rd_strobe && !ce_n) |=>
            (rd_data[7] == $past(wp_n) && rd_data[5:0] == 6'b0));

    // R9: status reads do not move the read position
    a_r9_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (status_mode && rd_strobe && !ev_ptr) |=> $stable(col_q));

    // R13: accepted erase drops ready on the next cycle
    a_r13_busy_after_erase: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && ev_erase && !ev_prog_commit && wp_n && page_in < PAGE_AW'(PAGES))
            |=> !ready);

    // R6: no array write happens while the block reports ready
    a_r6_no_write_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !ram_we);

    // R12: array accesses stay inside the array
    a_r12_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> ram_addr < MEM_AW'(DEPTH));
endmodule

bind nand_page_datapath nand_dp_checker #(
    .PAGE_AW(PAGE_AW), .COL_W(COL_W), .MEM_AW(MEM_AW),
    .PAGES(PAGES), .DEPTH(DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wp_n(wp_n),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .ready(ready),
    .ev_erase(ev_erase), .ev_prog_commit(ev_prog_commit),
    .ev_ptr(ev_read | ev_prog_start), .page_in(page_in),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .status_mode(mode_q == MD_STATUS), .col_q(col_q)
);

// File: tb/test_nand_page_datapath.sv
`timescale 1ns/1ps
module test_nand_page_datapath;
    localparam int PAGE_AW = 5;
    localparam int COL_W   = 9;
    localparam int ROW     = 66;

    logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b0, wp_n = 1'b1, spare_dis = 1'b0;
    logic ev_read = 0, ev_prog_start = 0, ev_prog_commit = 0, ev_erase = 0;
    logic ev_status = 0, ev_read_id = 0, wr_strobe = 0, rd_strobe = 0;
    logic [PAGE_AW-1:0] page_in = '0;
    logic [COL_W-1:0]   col_in = '0, off_in = '0;
    logic [7:0]         wr_data = '0, rd_data;
    logic               ready;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    nand_page_datapath i_nand_page_datapath (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wp_n(wp_n), .spare_dis(spare_dis),
        .ev_read(ev_read), .ev_prog_start(ev_prog_start),
        .ev_prog_commit(ev_prog_commit), .ev_erase(ev_erase),
        .ev_status(ev_status), .ev_read_id(ev_read_id),
        .page_in(page_in), .col_in(col_in), .off_in(off_in),
        .wr_strobe(wr_strobe), .wr_data(wr_data),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .ready(ready)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic rd(output logic [7:0] b);
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
        b = rd_data;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 5000 && !ready; i++) @(negedge clk);
    endtask

    task automatic do_read(input int pg, input int col, input int off);
        @(negedge clk);
        page_in = PAGE_AW'(pg); col_in = COL_W'(col); off_in = COL_W'(off); ev_read = 1;
        @(negedge clk) ev_read = 0;
    endtask

    task automatic prog(input int pg, input int col, input int n,
                        input logic [7:0] v0, input logic [7:0] step);
        @(negedge clk);
        page_in = PAGE_AW'(pg); col_in = COL_W'(col); ev_prog_start = 1;
        @(negedge clk) ev_prog_start = 0;
        for (int i = 0; i < n; i++) begin
            wr_data = v0 + 8'(i) * step; wr_strobe = 1;
            @(negedge clk) wr_strobe = 0;
        end
        ev_prog_commit = 1;
        @(negedge clk) ev_prog_commit = 0;
    endtask

    task automatic do_erase(input int pg);
        @(negedge clk);
        page_in = PAGE_AW'(pg); ev_erase = 1;
        @(negedge clk) ev_erase = 0;
    endtask

    task automatic expect_byte(input string req, input int pg, input int col,
                               input logic [7:0] exp);
        logic [7:0] b;
        do_read(pg, col, 0);
        rd(b);
        chk(req, b, exp);
    endtask

    task automatic t_reset();
        logic [7:0] b;
        int bad = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 ready low during clear", {7'b0, ready}, 8'h00);
        wait_ready();
        chk("R1 ready high after clear", {7'b0, ready}, 8'h01);
        do_read(5, 0, 0);
        for (int i = 0; i < ROW; i++) begin
            rd(b);
            if (b !== 8'hFF) bad++;
        end
        chk("R1 R2 full row reads FF", 8'(bad), 8'h00);
        rd(b);
        chk("R2 past end returns zero", b, 8'h00);
    endtask

    task automatic t_program();
        logic [7:0] b;
        prog(2, 4, 8, 8'h1C, 8'h10);
        chk("R13 ready low after commit", {7'b0, ready}, 8'h00);
        wait_ready();
        do_read(2, 0, 0);
        for (int i = 0; i < 14; i++) begin
            rd(b);
            chk("R2 R5 programmed row", b,
                (i >= 4 && i < 12) ? 8'h1C + 8'(i - 4) * 8'h10 : 8'hFF);
        end
        prog(2, 4, 8, 8'hF0, 8'h00);
        wait_ready();
        do_read(2, 4, 0);
        for (int i = 0; i < 8; i++) begin
            rd(b);
            chk("R5 second program ANDs", b, (8'h1C + 8'(i) * 8'h10) & 8'hF0);
        end
    endtask

    task automatic t_spare_len();
        logic [7:0] b;
        spare_dis = 1;
        do_read(2, 60, 0);
        for (int i = 0; i < 5; i++) begin
            rd(b);
            chk("R3 length without spare", b, (i < 4) ? 8'hFF : 8'h00);
        end
        spare_dis = 0;
        do_read(2, 60, 0);
        for (int i = 0; i < 7; i++) begin
            rd(b);
            chk("R2 length with spare", b, (i < 6) ? 8'hFF : 8'h00);
        end
    endtask

    task automatic t_offset();
        logic [7:0] b;
        prog(3, 64, 2, 8'h12, 8'h22);
        wait_ready();
        do_read(3, 0, 64);
        rd(b); chk("R4 offset start byte0", b, 8'h12);
        rd(b); chk("R4 offset start byte1", b, 8'h34);
        rd(b); chk("R4 offset cleared, stream ended", b, 8'h00);
    endtask

    task automatic t_ce();
        logic [7:0] b;
        do_read(2, 4, 0);
        ce_n = 1;
        rd(b); chk("R11 ce high returns zero", b, 8'h00);
        ce_n = 0;
        rd(b); chk("R11 stream not consumed", b, 8'h10);
        rd(b); chk("R11 stream continues", b, 8'h20);
    endtask

    task automatic t_overflow();
        prog(4, 0, 70, 8'h00, 8'h00);
        wait_ready();
        expect_byte("R7 last row byte programmed", 4, 65, 8'h00);
        expect_byte("R7 next page untouched", 5, 0, 8'hFF);
    endtask

    task automatic t_wp();
        wp_n = 0;
        prog(6, 0, 4, 8'h00, 8'h00);
        chk("R6 commit ignored, ready high", {7'b0, ready}, 8'h01);
        expect_byte("R6 protected page unchanged", 6, 0, 8'hFF);
        do_erase(4);
        chk("R6 erase ignored, ready high", {7'b0, ready}, 8'h01);
        expect_byte("R6 protected erase kept data", 4, 0, 8'h00);
        wp_n = 1;
    endtask

    task automatic t_erase();
        do_erase(2);
        chk("R13 ready low after erase", {7'b0, ready}, 8'h00);
        wait_ready();
        expect_byte("R8 erased page 2", 2, 4, 8'hFF);
        expect_byte("R8 erased page 3 spare", 3, 64, 8'hFF);
        expect_byte("R8 page outside block kept", 4, 0, 8'h00);
    endtask

    task automatic t_status();
        logic [7:0] b;
        @(negedge clk) ev_status = 1;
        @(negedge clk) ev_status = 0;
        rd(b); chk("R9 status ready", b, 8'hC0);
        rd(b); chk("R9 status repeats", b, 8'hC0);
        wp_n = 0;
        rd(b); chk("R9 status shows protect", b, 8'h40);
        wp_n = 1;
        do_erase(8);
        @(negedge clk) ev_status = 1;
        @(negedge clk) ev_status = 0;
        rd(b); chk("R9 status busy", b, 8'h80);
        rd(b); chk("R9 status busy repeats", b, 8'h80);
        wait_ready();
        rd(b); chk("R9 status ready again", b, 8'hC0);
    endtask

    task automatic t_id();
        logic [7:0] b;
        logic [7:0] exp [5] = '{8'hEC, 8'hF1, 8'hA5, 8'h15, 8'h00};
        @(negedge clk) ev_read_id = 1;
        @(negedge clk) ev_read_id = 0;
        for (int i = 0; i < 5; i++) begin
            rd(b);
            chk("R10 id sequence", b, exp[i]);
        end
    endtask

    task automatic t_range();
        logic [7:0] b;
        do_read(20, 0, 0);
        rd(b); chk("R12 out of range read zero", b, 8'h00);
        prog(16, 0, 4, 8'h00, 8'h00);
        chk("R12 out of range program ignored", {7'b0, ready}, 8'h01);
        expect_byte("R12 page 0 unchanged", 0, 0, 8'hFF);
        do_erase(17);
        chk("R12 out of range erase ignored", {7'b0, ready}, 8'h01);
    endtask

    initial begin
        t_reset();
        t_program();
        t_spare_len();
        t_offset();
        t_ce();
        t_overflow();
        t_wp();
        t_erase();
        t_status();
        t_id();
        t_range();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule